// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged Queue

This block turns an asynchronous serial line into received characters. A one-cycle enable pulses at sixteen times the bit rate. The line passes through a two-flop synchronizer. A falling edge starts a candidate frame. That start is confirmed only if the line is still low on the eighth enable pulse, which is the middle of the start bit. Every later bit is sampled sixteen pulses after the one before it.

Each finished character is checked for parity, stop-bit and break conditions. It is stored with three flag bits that travel with it through the storage.

The storage works in one of two modes. With `queue_on` high it is a 16-entry first-in first-out buffer. With `queue_on` low it acts as a single holding register. The host sees the character at the head of the storage and that character's three flags. It removes the character with a one-cycle read strobe. The character length and the parity settings are plain inputs, so the transmitter can share them.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset, `rx_valid`, `rx_overrun`, `rx_ready`, `err_parity`, `err_frame` and `err_break` are all 0.
- R2: Bits arrive least significant first. `len_sel` sets the data length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 bits. The character appears on `rd_data` right-aligned, with the unused upper bits at 0.
- R3: With `par_on` high, one parity bit follows the data. `par_even` = 1 means the data plus the parity bit must hold an even number of ones; 0 means odd. A mismatch sets `err_parity` for that character. With `par_on` low, no parity bit is expected and `err_parity` stays 0.
- R4: If the stop bit is sampled low, `err_frame` is set for that character.
- R5: If the data, the parity bit (when present) and the stop bit are all sampled low, exactly one character of value 0 is stored, with both `err_break` and `err_frame` set. No further character is stored until the line has gone high and fallen again.
- R6: If the line is high again at the middle of the start bit, the receiver goes back to idle and stores nothing.
- R7: In queue mode, up to 16 characters are kept and read back in arrival order, each with its own flags. When `rx_valid` is 0, all three error outputs are 0.
- R8: In single-register mode, a character that completes while the register is occupied is dropped and sets `rx_overrun`. The held character is unchanged.
- R9: In queue mode, a character that completes while 16 are stored is dropped and sets `rx_overrun`. The 16 stored characters are preserved. `rx_overrun` clears on the next read strobe that removes a character.
- R10: In queue mode, `rx_ready` is high while the stored count is at least `READY_AT` (default 4). In single-register mode, `rx_ready` equals `rx_valid`.
- R11: A read strobe while nothing is stored has no effect.
- R12: Changing `queue_on` empties the storage and clears `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Data length select (5 to 8 bits) |
| par_on | input | 1 | A parity bit is present |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| queue_on | input | 1 | 1 selects 16-entry queue, 0 selects single register |
| rd_strobe | input | 1 | Removes the head character |
| rd_data | output | 8 | Head character |
| rx_valid | output | 1 | At least one character is stored |
| rx_overrun | output | 1 | A character was dropped because storage was full |
| err_parity | output | 1 | Parity flag of the head character |
| err_frame | output | 1 | Framing flag of the head character |
| err_break | output | 1 | Break flag of the head character |
| rx_ready | output | 1 | Receive-ready indication |

## Verification
The assertions check four things on every cycle:
- The stored count never exceeds the capacity of the active mode.
- An overrun leaves the count unchanged.
- A read strobe on empty storage leaves it empty.
- A break entry reads as zero, and the flags are masked when nothing is stored.

Only the scenarios can show the rest:
- the bit timing and the right-alignment of short characters;
- the correct parity sense;
- the rejection of false starts;
- first-in first-out order under a full queue;
- the dropping of the seventeenth character;
- the single stored break character.

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DEPTH    = 16,
  parameter int READY_AT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_in,
  input  logic [1:0] len_sel,
  input  logic       par_on,
  input  logic       par_even,
  input  logic       queue_on,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic       rx_valid,
  output logic       rx_overrun,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_break,
  output logic       rx_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic       sy1, sy2, sy3;
  st_t        st;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] shreg;
  logic       par_bit;
  logic       pend_v;
  logic [10:0] pend_w;

  logic [10:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap;
  logic        mode_q;

  logic [7:0] data_al;
  logic       full, do_push, do_pop, mode_chg;

  assign data_al  = shreg >> (2'd3 - len_sel);
  assign cap      = queue_on ? CW'(DEPTH) : CW'(1);
  assign full     = (cnt >= cap);
  assign mode_chg = (queue_on != mode_q);
  assign do_push  = pend_v && !full && !mode_chg;
  assign do_pop   = rd_strobe && (cnt != 0) && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sy1, sy2, sy3} <= 3'b111;
    end else begin
      sy1 <= rx_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      pend_v  <= 1'b0;
      pend_w  <= '0;
    end else begin
      pend_v <= 1'b0;
      case (st)
        S_IDLE: if (sy3 && !sy2) begin
          st   <= S_START;
          tcnt <= '0;
        end
        S_START: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            bidx <= '0;
            st   <= sy2 ? S_IDLE : S_DATA;
          end
        end
        S_DATA: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            shreg <= {sy2, shreg[7:1]};
            bidx  <= bidx + 3'd1;
            if (bidx == {1'b0, len_sel} + 3'd4)
              st <= par_on ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            par_bit <= sy2;
            st      <= S_STOP;
          end
        end
        S_STOP: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            st     <= S_IDLE;
            pend_v <= 1'b1;
            pend_w <= {(data_al == 8'd0) && !(par_on && par_bit) && !sy2,
                       !sy2,
                       par_on && ((^data_al ^ par_bit) == par_even),
                       data_al};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= pend_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp         <= '0;
      rp         <= '0;
      cnt        <= '0;
      mode_q     <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      mode_q <= queue_on;
      if (mode_chg) begin
        wp         <= '0;
        rp         <= '0;
        cnt        <= '0;
        rx_overrun <= 1'b0;
      end else begin
        if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
        if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
        if (pend_v && full) rx_overrun <= 1'b1;
        else if (do_pop)    rx_overrun <= 1'b0;
      end
    end
  end

  assign rx_valid   = (cnt != 0);
  assign rd_data    = rx_valid ? mem[rp][7:0] : 8'd0;
  assign err_parity = rx_valid && mem[rp][8];
  assign err_frame  = rx_valid && mem[rp][9];
  assign err_break  = rx_valid && mem[rp][10];
  assign rx_ready   = queue_on ? (cnt >= CW'(READY_AT)) : rx_valid;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> cnt <= cap);
  assert_keep_on_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && full && !rd_strobe && !mode_chg) |=> cnt == $past(cnt));
  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cnt == 0 && !pend_v && !mode_chg) |=> cnt == 0);
  assert_break_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && err_break) |-> (rd_data == 8'd0 && err_frame));
  assert_flags_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(err_parity || err_frame || err_break));
endmodule

// File: tb/serial_rx_queue_bench.sv
module serial_rx_queue_bench;
  logic clk = 0, rst_n = 0, os_tick = 0, rx_in = 1;
  logic [1:0] len_sel = 2'd3;
  logic par_on = 0, par_even = 1, queue_on = 1, rd_strobe = 0;
  logic [7:0] rd_data;
  logic rx_valid, rx_overrun, err_parity, err_frame, err_break, rx_ready;
  int tests = 0, fails = 0, tdiv = 0;

  localparam int BIT = 64;

  serial_rx_queue u_serial_rx_queue (.clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .rx_in(rx_in), .len_sel(len_sel), .par_on(par_on), .par_even(par_even),
    .queue_on(queue_on), .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_valid(rx_valid),
    .rx_overrun(rx_overrun), .err_parity(err_parity), .err_frame(err_frame),
    .err_break(err_break), .rx_ready(rx_ready));

  always #4 clk = ~clk;
  always @(posedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    os_tick <= (tdiv == 3);
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pe,
                      input bit pv, input bit stopv);
    @(negedge clk) rx_in = 0;
    idle(BIT);
    for (int i = 0; i < nb; i++) begin
      rx_in = d[i];
      idle(BIT);
    end
    if (pe) begin
      rx_in = pv;
      idle(BIT);
    end
    rx_in = stopv;
    idle(BIT);
    rx_in = 1;
    idle(BIT);
  endtask

  task automatic rd_chk(input string req, input int d, input bit p, input bit f, input bit b);
    chk(req, rx_valid, 1);
    chk(req, {err_break, err_frame, err_parity, rd_data}, {b, f, p, d[7:0]});
    rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
  endtask

  task automatic t_reset;
    chk("R1", {rx_valid, rx_overrun, rx_ready, err_parity, err_frame, err_break}, 0);
  endtask

  task automatic t_lengths;
    for (int l = 0; l < 4; l++) begin
      len_sel = 2'(l);
      send(8'hB5, l + 5, 0, 0, 1);
      rd_chk("R2", 8'hB5 & ((1 << (l + 5)) - 1), 0, 0, 0);
    end
    len_sel = 2'd3;
  endtask

  task automatic t_parity;
    par_on = 1;
    par_even = 1; send(8'h07, 8, 1, 1, 1); rd_chk("R3 even ok", 8'h07, 0, 0, 0);
    par_even = 1; send(8'h07, 8, 1, 0, 1); rd_chk("R3 even bad", 8'h07, 1, 0, 0);
    par_even = 0; send(8'h03, 8, 1, 1, 1); rd_chk("R3 odd ok", 8'h03, 0, 0, 0);
    par_even = 0; send(8'h03, 8, 1, 0, 1); rd_chk("R3 odd bad", 8'h03, 1, 0, 0);
    par_on = 0;
  endtask

  task automatic t_framing;
    send(8'h5A, 8, 0, 0, 0);
    rd_chk("R4", 8'h5A, 0, 1, 0);
  endtask

  task automatic t_break;
    @(negedge clk) rx_in = 0;
    idle(BIT * 14);
    rx_in = 1;
    idle(BIT * 2);
    rd_chk("R5 break", 0, 0, 1, 1);
    chk("R5 single", rx_valid, 0);
  endtask

  task automatic t_false_start;
    @(negedge clk) rx_in = 0;
    idle(20);
    rx_in = 1;
    idle(BIT * 12);
    chk("R6 nothing", rx_valid, 0);
    send(8'h3C, 8, 0, 0, 1);
    rd_chk("R6 next", 8'h3C, 0, 0, 0);
  endtask

  task automatic t_ready_and_order;
    for (int i = 0; i < 17; i++) begin
      if (i == 3) chk("R10 below", rx_ready, 0);
      if (i == 4) chk("R10 at", rx_ready, 1);
      send(8'h40 + 8'(i), 8, 0, 0, (i == 5) ? 1'b0 : 1'b1);
    end
    chk("R9 overrun", rx_overrun, 1);
    for (int i = 0; i < 16; i++) rd_chk("R7 R9 order", 8'h40 + i, 0, (i == 5), 0);
    chk("R9 cleared", rx_overrun, 0);
    chk("R7 empty", rx_valid, 0);
  endtask

  task automatic t_empty_read;
    rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    idle(2);
    chk("R11", {rx_valid, rx_overrun}, 0);
    send(8'h11, 8, 0, 0, 1);
    rd_chk("R11 after", 8'h11, 0, 0, 0);
  endtask

  task automatic t_single;
    queue_on = 0;
    idle(2);
    send(8'hA1, 8, 0, 0, 1);
    chk("R10 single", rx_ready, 1);
    send(8'hA2, 8, 0, 0, 1);
    chk("R8 overrun", rx_overrun, 1);
    rd_chk("R8 kept", 8'hA1, 0, 0, 0);
    chk("R8 cleared", {rx_valid, rx_overrun, rx_ready}, 0);
  endtask

  task automatic t_mode_switch;
    queue_on = 1;
    idle(2);
    send(8'h21, 8, 0, 0, 1);
    send(8'h22, 8, 0, 0, 1);
    chk("R12 loaded", rx_valid, 1);
    queue_on = 0;
    idle(2);
    chk("R12 flushed", rx_valid, 0);
    queue_on = 1;
    idle(2);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1;
    idle(5);
    t_lengths();
    t_parity();
    t_framing();
    t_break();
    t_false_start();
    t_ready_and_order();
    t_empty_read();
    t_single();
    t_mode_switch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule